// File: doc/BRIEF.md
# GPIO Bank Controller with Masked Writes and Pin Interrupts

This block controls one bank of 32 general-purpose pins, grouped as four ports of eight pins. For each pin, software chooses whether the pin is owned by this block or left to an alternate function, whether it drives, and what level it drives. Software can also read back the synchronized pad level. Each pin has its own interrupt detector, which senses a high or low level, a rising or falling edge, or both edges. Each pin also has a status bit and an enable bit. The enabled, pending pins of the whole bank are combined into one interrupt line.

Registers are reached over a simple single-cycle 32-bit read/write bus. Each port's register sits at `group*0x10 + port*4`. For most control groups there is also a second, aliased window with address bit 7 set. A write through the alias changes only the pins selected in the upper byte of the data, so different software threads can update separate pins without a read-modify-write.

Top module: `gpio_bank`

## Requirements
- R1: The port index is address bits 3:2 and the group is address bits 6:4, with groups 0 config, 1 drive-enable, 2 output, 3 input, 4 status, 5 interrupt enable, 6 type and 7 clear. Read data appears on `bus_rdata` in the cycle after `bus_rd`. The clear group and the whole alias window (address bit 7 set) read as zero.
- R2: After reset every config, drive-enable, output, enable, type and status register holds 0, and `pad_oe` and `irq` are low.
- R3: A write to `0x80 + group*0x10 + port*4` for group 0, 1, 2, 4 or 5 changes only the pins whose bit in data 15:8 is 1. Each such pin takes the value of the matching bit in data 7:0; all other pins keep their value.
- R4: An alias write to the type group (offset 0xE0 + port*4) updates only the polarity plane (type bits 7:0) of the selected pins. The edge plane and the both-edges plane stay as they were.
- R5: `pad_oe` of a pin is high only when both its config bit and its drive-enable bit are 1. `pad_out` shows the output register and `pin_gpio_mode` shows the config register.
- R6: Reading the input group returns the pad levels after a two-flop synchronizer, so a pad change is readable after two clock edges. Writes to the input group have no effect.
- R7: In the type register, pin n uses bit n for polarity (1 = high/rising), bit n+8 for edge mode and bit n+16 for both-edge mode. The encodings (bit16, bit8, bit0) are: rising 0,1,1; falling 0,1,0; both 1,1,0; level high 0,0,1; level low 0,0,0. A qualifying pad change before clock edge k sets status at edge k+2.
- R8: In edge mode a status bit stays set until a 1 is written to its bit in the clear group. Writing a 0 there leaves it unchanged.
- R9: When an edge event and a clear of the same pin happen in the same cycle, the status bit ends up set.
- R10: In level mode the status bit follows the synchronized level condition. A clear has no lasting effect while the level is still asserted, and the bit falls when the level goes away.
- R11: `irq` is high exactly when some pin in any of the four ports has both its status and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output values toward the pads |
| pad_oe | output | 32 | Pad drive enables |
| pin_gpio_mode | output | 32 | 1 where the pin is owned by this block |
| irq | output | 1 | Combined bank interrupt |

## Verification
Some properties hold at every clock edge, and the assertions check them continuously. An edge-mode status bit cannot drop unless its port was written. A clear of a pin with no concurrent event always takes effect. A concurrent edge always wins over a clear. A level-mode status bit always tracks the sensed level. Alias writes leave unselected pins alone, the interrupt line is quiet just after reset, and the clear group reads zero. Other behaviours only show up in the bench scenarios. These are the exact encoding of each of the five sense types, the two-edge latency from pad to status, the polarity-only effect of a masked type write, the OR of pending pins across ports, and the precise cycle alignment of the event-versus-clear collision.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank: register group codes.
// Assumes group codes are decoded from address bits 6:4.
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        GRP_CNF = 3'd0,
        GRP_OE  = 3'd1,
        GRP_OUT = 3'd2,
        GRP_IN  = 3'd3,
        GRP_STA = 3'd4,
        GRP_ENB = 3'd5,
        GRP_TYP = 3'd6,
        GRP_CLR = 3'd7
    } grp_e;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for asynchronous pad levels.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_irq_sense.sv
// Per-pin interrupt sensing for one port: edge events and level conditions.
// Assumes lvl is already synchronized; typ holds polarity, edge and
// both-edge planes at offsets 0, W and 2W.
module gpio_irq_sense #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl,
    input  logic [3*W-1:0] typ,
    output logic [W-1:0]   hit,
    output logic [W-1:0]   level_on,
    output logic [W-1:0]   edge_mode
);
    logic [W-1:0] prev;

    // Remember last synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic pol, em, both, rise, fall;
        assign pol  = typ[i];
        assign em   = typ[W + i];
        assign both = typ[2*W + i];
        assign rise = lvl[i] & ~prev[i];
        assign fall = ~lvl[i] & prev[i];

        // Decode the sense mode into an event or a level condition.
        always_comb begin
            if (both)     hit[i] = em & (rise | fall);
            else if (pol) hit[i] = em & rise;
            else          hit[i] = em & fall;
            level_on[i] = ~em & (pol ? lvl[i] : ~lvl[i]);
        end
        assign edge_mode[i] = em;
    end
endmodule

// File: rtl/gpio_port.sv
// Register set for one port of W pins: config, drive-enable, output,
// interrupt enable, type and status, with masked-write support.
// Assumes the parent has decoded the port address; wr_grp and wr_alias
// come straight from the address.
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hit,
    input  logic           wr_alias,
    input  grp_e           wr_grp,
    input  logic [3*W-1:0] wdata,
    input  logic [W-1:0]   lvl,
    output logic [W-1:0]   cnf_q,
    output logic [W-1:0]   oe_q,
    output logic [W-1:0]   out_q,
    output logic [W-1:0]   enb_q,
    output logic [W-1:0]   sta_q,
    output logic [3*W-1:0] typ_q,
    output logic           pend
);
    logic [W-1:0] sel, val, hit, level_on, edge_mode, clr_bits, sta_d;
    logic         wr_clr, wr_sta, wr_typ;

    assign sel    = wr_alias ? wdata[2*W-1:W] : '1;
    assign val    = wdata[W-1:0];
    assign wr_clr = wr_hit && !wr_alias && (wr_grp == GRP_CLR);
    assign wr_sta = wr_hit && (wr_grp == GRP_STA);
    assign wr_typ = wr_hit && (wr_grp == GRP_TYP);
    assign clr_bits = wr_clr ? val : '0;

    gpio_irq_sense #(.W(W)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .typ       (typ_q),
        .hit       (hit),
        .level_on  (level_on),
        .edge_mode (edge_mode)
    );

    // Update the plain control registers on a (masked) write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnf_q <= '0;
            oe_q  <= '0;
            out_q <= '0;
            enb_q <= '0;
        end else if (wr_hit) begin
            case (wr_grp)
                GRP_CNF: cnf_q <= (cnf_q & ~sel) | (val & sel);
                GRP_OE:  oe_q  <= (oe_q  & ~sel) | (val & sel);
                GRP_OUT: out_q <= (out_q & ~sel) | (val & sel);
                GRP_ENB: enb_q <= (enb_q & ~sel) | (val & sel);
                default: ;
            endcase
        end
    end

    // Update the type planes; the alias touches only the polarity plane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            typ_q <= '0;
        end else if (wr_typ) begin
            if (wr_alias) typ_q[W-1:0] <= (typ_q[W-1:0] & ~sel) | (val & sel);
            else          typ_q        <= wdata;
        end
    end

    // Next status: sticky with clear for edge pins, live for level pins.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (edge_mode[i]) begin
                if (wr_sta && sel[i]) sta_d[i] = val[i] | hit[i];
                else                  sta_d[i] = (sta_q[i] & ~clr_bits[i]) | hit[i];
            end else begin
                sta_d[i] = level_on[i];
            end
        end
    end

    // Register the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) sta_q <= '0;
        else        sta_q <= sta_d;
    end

    assign pend = |(sta_q & enb_q);

    // R8: edge status never drops while the port is not written.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && |(sta_q & edge_mode)) |=> (($past(sta_q & edge_mode) & ~sta_q) == '0));

    // R8: a clear of an edge pin with no concurrent event takes effect.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && |(val & edge_mode & ~hit)) |=> (($past(val & edge_mode & ~hit) & sta_q) == '0));

    // R9: an edge event always leaves status set, even against a clear.
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & edge_mode) && !wr_typ) |=> (($past(hit & edge_mode) & ~sta_q) == '0));

    // R10: level-mode status equals the sensed level condition.
    p_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_typ |=> ((sta_q & ~$past(edge_mode)) == $past(level_on)));

    // R3: unselected pins keep their config value on an alias write.
    p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_alias && wr_grp == GRP_CNF) |=> ((cnf_q & ~$past(sel)) == ($past(cnf_q) & ~$past(sel))));
endmodule

// File: rtl/gpio_bank.sv
// One GPIO bank: NUM_PORTS ports of PORT_W pins, a register bus with
// masked-write alias window, pad synchronization and a combined interrupt.
// Assumes NUM_PORTS*4 <= 16 so port registers fit inside a 0x10 group,
// and DATA_W >= 3*PORT_W so the type planes fit one word.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pin_gpio_mode,
    output logic                        irq
);
    localparam int PINS      = NUM_PORTS * PORT_W;
    localparam int PSW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int PORT_LSB  = 2;
    localparam int GRP_LSB   = 4;
    localparam int ALIAS_BIT = 7;
    localparam int TYP_W     = 3 * PORT_W;

    logic [PINS-1:0]   pad_sync;
    logic              aligned, is_alias;
    logic [PSW-1:0]    port_idx;
    grp_e              grp;
    logic [DATA_W-1:0] rd_mux;
    logic [NUM_PORTS-1:0] pend;
    logic              unused_hi;

    logic [PORT_W-1:0] cnf_a [NUM_PORTS];
    logic [PORT_W-1:0] oe_a  [NUM_PORTS];
    logic [PORT_W-1:0] out_a [NUM_PORTS];
    logic [PORT_W-1:0] enb_a [NUM_PORTS];
    logic [PORT_W-1:0] sta_a [NUM_PORTS];
    logic [TYP_W-1:0]  typ_a [NUM_PORTS];

    assign aligned   = (bus_addr[PORT_LSB-1:0] == '0);
    assign is_alias  = bus_addr[ALIAS_BIT];
    assign port_idx  = bus_addr[PORT_LSB +: PSW];
    assign grp       = grp_e'(bus_addr[GRP_LSB +: 3]);
    assign unused_hi = ^bus_wdata[DATA_W-1:TYP_W];

    gpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit_p;
        assign hit_p = bus_wr && aligned && (port_idx == PSW'(p));

        gpio_port #(.W(PORT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit_p),
            .wr_alias (is_alias),
            .wr_grp   (grp),
            .wdata    (bus_wdata[TYP_W-1:0]),
            .lvl      (pad_sync[p*PORT_W +: PORT_W]),
            .cnf_q    (cnf_a[p]),
            .oe_q     (oe_a[p]),
            .out_q    (out_a[p]),
            .enb_q    (enb_a[p]),
            .sta_q    (sta_a[p]),
            .typ_q    (typ_a[p]),
            .pend     (pend[p])
        );

        assign pad_out[p*PORT_W +: PORT_W]       = out_a[p];
        assign pad_oe[p*PORT_W +: PORT_W]        = cnf_a[p] & oe_a[p];
        assign pin_gpio_mode[p*PORT_W +: PORT_W] = cnf_a[p];
    end

    // Select the addressed register for a read; alias window reads zero.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_idx == PSW'(p) && aligned && !is_alias) begin
                case (grp)
                    GRP_CNF: rd_mux = DATA_W'(cnf_a[p]);
                    GRP_OE:  rd_mux = DATA_W'(oe_a[p]);
                    GRP_OUT: rd_mux = DATA_W'(out_a[p]);
                    GRP_IN:  rd_mux = DATA_W'(pad_sync[p*PORT_W +: PORT_W]);
                    GRP_STA: rd_mux = DATA_W'(sta_a[p]);
                    GRP_ENB: rd_mux = DATA_W'(enb_a[p]);
                    GRP_TYP: rd_mux = DATA_W'(typ_a[p]);
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    // Capture read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = |pend;

    // R2: interrupt line and drive enables are quiet right after reset.
    p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq && pad_oe == '0));

    // R1: the clear group always reads as zero.
    p_clr_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_alias && grp == GRP_CLR) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_bank_tb.sv
// Scoreboard bench: read tasks push expected words, a monitor compares them.
module gpio_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in, pad_out, pad_oe, pin_gpio_mode;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    logic rd_seen;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pad_in        (pad_in),
        .pad_out       (pad_out),
        .pad_oe        (pad_oe),
        .pin_gpio_mode (pin_gpio_mode),
        .irq           (irq)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare each returned read word with the queued expectation.
    always @(negedge clk) begin
        if (rd_seen === 1'b1 && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: read actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic check(string t, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string t);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; pad_in = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2: reset state
        check("R2 pad_oe", pad_oe, 32'h0);
        check("R2 irq", {31'b0, irq}, 32'h0);
        rd(8'h04, 32'h0, "R2 config p1");
        rd(8'h5C, 32'h0, "R2 enable p3");
        rd(8'h68, 32'h0, "R2 type p2");

        // R1 plain write and read; R3 masked write
        wr(8'h04, 32'hF0);
        rd(8'h04, 32'hF0, "R1 config p1");
        wr(8'h84, 32'h0F05);
        rd(8'h04, 32'hF5, "R3 masked config p1");

        // R5 pad enables and output
        wr(8'h14, 32'h3C);
        wr(8'hA4, 32'hFFAA);
        idle(1);
        check("R5 pad_oe", pad_oe, 32'h0000_3400);
        check("R5 pad_out", pad_out, 32'h0000_AA00);
        check("R5 gpio_mode", pin_gpio_mode, 32'h0000_F500);

        // R6 synchronized input, writes ignored
        pad_in[23:16] = 8'h5A;
        idle(3);
        rd(8'h38, 32'h5A, "R6 input p2");
        wr(8'h38, 32'hFF);
        rd(8'h38, 32'h5A, "R6 input write ignored");

        // R7 rising pin0, R11 irq, R8 sticky and clear
        wr(8'h60, 32'h000101);
        wr(8'h50, 32'h01);
        wr(8'h70, 32'h01);
        pad_in[0] = 1'b1;
        idle(3);
        check("R11 irq on rise", {31'b0, irq}, 32'h1);
        rd(8'h40, 32'hFF, "R7 rising status");
        pad_in[0] = 1'b0;
        idle(3);
        rd(8'h40, 32'hFF, "R8 sticky after fall");
        wr(8'h70, 32'h00);
        rd(8'h40, 32'hFF, "R8 clear with zero");
        wr(8'h70, 32'h01);
        rd(8'h40, 32'hFE, "R8 clear with one");
        check("R11 irq off", {31'b0, irq}, 32'h0);

        // R7 falling pin1
        wr(8'h60, 32'h000301);
        wr(8'h70, 32'h02);
        pad_in[1] = 1'b1;
        idle(3);
        rd(8'h40, 32'hFC, "R7 falling ignores rise");
        pad_in[1] = 1'b0;
        idle(3);
        rd(8'h40, 32'hFE, "R7 falling sets");

        // R7 both edges pin2
        wr(8'h60, 32'h040701);
        wr(8'h70, 32'h04);
        pad_in[2] = 1'b1;
        idle(3);
        rd(8'h40, 32'hFE, "R7 both rise");
        wr(8'h70, 32'h04);
        pad_in[2] = 1'b0;
        idle(3);
        rd(8'h40, 32'hFE, "R7 both fall");

        // R10 level high pin3
        wr(8'h60, 32'h040709);
        idle(2);
        rd(8'h40, 32'hF6, "R10 level high idle");
        pad_in[3] = 1'b1;
        idle(3);
        rd(8'h40, 32'hFE, "R10 level high asserted");
        wr(8'h70, 32'h08);
        rd(8'h40, 32'hFE, "R10 clear while asserted");
        pad_in[3] = 1'b0;
        idle(3);
        rd(8'h40, 32'hF6, "R10 level gone");

        // R9 edge and clear in the same cycle
        pad_in[0] = 1'b1;
        idle(2);
        wr(8'h70, 32'h01);
        rd(8'h40, 32'hF7, "R9 edge wins over clear");
        check("R9 irq held", {31'b0, irq}, 32'h1);

        // R4 masked type write touches only polarity
        wr(8'hE0, 32'h0100);
        rd(8'h60, 32'h040708, "R4 masked type");
        wr(8'h70, 32'h01);
        pad_in[0] = 1'b0;
        idle(3);
        rd(8'h40, 32'hF7, "R4 pin0 now falling");

        // R3 masked enable, R11 OR across ports
        wr(8'hD0, 32'h0100);
        idle(1);
        check("R3 irq after masked enable clear", {31'b0, irq}, 32'h0);
        rd(8'h50, 32'h0, "R3 enable p0");
        wr(8'h5C, 32'h80);
        idle(1);
        check("R11 irq from port3", {31'b0, irq}, 32'h1);
        wr(8'h5C, 32'h00);
        idle(1);
        check("R11 irq port3 off", {31'b0, irq}, 32'h0);

        // R1 clear group and alias window read zero
        rd(8'h70, 32'h0, "R1 clear reads zero");
        rd(8'h84, 32'h0, "R1 alias reads zero");
        idle(2);
        finish_run();
    end
endmodule